// File: doc/BRIEF.md
# Free-Running Timer with Overflow Flag

This block is a free-running up-counter with a sticky overflow status bit. Software reaches it over a small synchronous register bus. It can read the live count, read and write a control register, and read the status register. It can also clear the overflow bit, either by writing a 1 to it or, in fast-clear mode, just by touching the counter register.

An interrupt request is formed from the overflow bit and an enable bit in the control register. The request stays high until software clears the bit.

The bus has four word addresses:

| Address | Register |
|---|---|
| 0 | count, read-only |
| 1 | control |
| 2 | status |
| 3 | unmapped |

Read data is a combinational decode of the address. An access is any cycle with `bus_sel` high, and `bus_wr` picks write over read. Write effects take hold at the next rising clock edge.

Top module: `free_run_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is 0x0000, the control register is 0, the overflow bit is 0 and `irq` is low.
- R2: While control bit 0 (run) is 1, the count advances by exactly one on every clock edge and wraps from 0xFFFF to 0x0000.
- R3: While the run bit is 0, the count holds its value.
- R4: The overflow bit becomes 1 on the clock edge where the count steps from 0xFFFF to 0x0000. A read of address 2 then returns 0x0080.
- R5: The status register at address 2 can be read at any time. It shows the overflow bit in bit 7, and every other bit reads 0.
- R6: A write to address 2 with data bit 7 set clears the overflow bit. A write with bit 7 clear leaves it unchanged.
- R7: When control bit 1 (fast clear) is 1, any access to address 0, read or write, clears the overflow bit. When that control bit is 0, such accesses leave the overflow bit unchanged.
- R8: Writes to address 0 never change the count value.
- R9: `irq` is high exactly while the overflow bit and control bit 2 (interrupt enable) are both 1. It stays high until the overflow bit is cleared.
- R10: If a wrap and a clear fall on the same edge, the overflow bit ends up 1.
- R11: The control register at address 1 stores write-data bits 2:0 and reads back with all upper bits 0. Address 3 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands on the very edge where the count wraps. Proving that set wins needs a write-1 to the status register in exactly the cycle the count reads 0xFFFF.

The stimulus watches the count through the read port with `bus_sel` held low, so that fast-clear access is not triggered while waiting. When it sees 0xFFFF, it issues the clear in that same cycle.

Each of the three real wraps is then used for a different clearing path:
- the coincident write-1 clear;
- a fast-clear read of the counter;
- a fast-clear write to the counter, which must also leave the count untouched.

// File: rtl/frt_pkg.sv
// Shared definitions for the free-running timer: register addresses and
// control-bit positions. Assumes a word-addressed bus with a 2-bit address.
package frt_pkg;
    localparam int ADDR_W    = 2;
    localparam int CTL_BITS  = 3;
    localparam int CTL_RUN   = 0;
    localparam int CTL_FAST  = 1;
    localparam int CTL_IE    = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CNT  = 2'd0,
        REG_CTL  = 2'd1,
        REG_FLG  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/frt_counter.sv
// Free-running up-counter. Advances by one per clock while run is high and
// reports the wrap edge. Assumes run is a registered control bit.
module frt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    // Wrap happens on the edge that leaves the all-ones value while running.
    assign wrap = run && (count == {CNT_W{1'b1}});

    // Counter register: reset to zero, step by one when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (count == $past(count) + 1'b1));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));
endmodule

// File: rtl/frt_ctrl.sv
// Control register and bus decode. Holds run / fast-clear / interrupt-enable
// bits and turns bus accesses into a single overflow-clear request.
// Assumes one access per cycle, qualified by sel.
module frt_ctrl #(
    parameter int DATA_W   = 16,
    parameter int FLAG_POS = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sel,
    input  logic                         wr,
    input  logic [frt_pkg::ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [frt_pkg::CTL_BITS-1:0] ctl,
    output logic                         run,
    output logic                         ie,
    output logic                         clr_req
);
    import frt_pkg::*;

    logic fast;
    logic w1c_hit;
    logic cnt_touch;
    logic wdata_unused;

    // Only the low control bits and the flag bit are consumed.
    assign wdata_unused = ^wdata;

    assign run  = ctl[CTL_RUN];
    assign fast = ctl[CTL_FAST];
    assign ie   = ctl[CTL_IE];

    // Clear sources: write-one to the flag bit, or counter access in fast mode.
    assign w1c_hit   = sel && wr && (addr == REG_FLG) && wdata[FLAG_POS];
    assign cnt_touch = sel && (addr == REG_CNT) && fast;
    assign clr_req   = w1c_hit || cnt_touch;

    // Control register: loaded from write data on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (sel && wr && (addr == REG_CTL)) begin
            ctl <= wdata[CTL_BITS-1:0];
        end
    end

    p_ctl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == REG_CTL) |=> (ctl == $past(wdata[CTL_BITS-1:0])));
endmodule

// File: rtl/frt_flag.sv
// Sticky overflow bit with clear request and masked interrupt output.
// A set on the same edge as a clear takes priority.
module frt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie,
    output logic flag,
    output logic irq
);
    // Interrupt is the flag gated by its enable.
    assign irq = flag && ie;

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_i) begin
            flag <= 1'b1;
        end else if (clr_i) begin
            flag <= 1'b0;
        end
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag);

    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag));

    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq);
endmodule

// File: rtl/free_run_timer.sv
// Top of the free-running timer: counter, control/decode and overflow flag,
// plus the combinational read-data mux. Assumes CNT_W <= DATA_W and
// FLAG_POS < DATA_W.
module free_run_timer #(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int FLAG_POS = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [frt_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       irq
);
    import frt_pkg::*;

    localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_POS;

    logic [CNT_W-1:0]    count;
    logic                wrap;
    logic [CTL_BITS-1:0] ctl;
    logic                run;
    logic                ie;
    logic                clr_req;
    logic                flag;

    frt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .count (count),
        .wrap  (wrap)
    );

    frt_ctrl #(.DATA_W(DATA_W), .FLAG_POS(FLAG_POS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ctl     (ctl),
        .run     (run),
        .ie      (ie),
        .clr_req (clr_req)
    );

    frt_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wrap),
        .clr_i (clr_req),
        .ie    (ie),
        .flag  (flag),
        .irq   (irq)
    );

    // Read mux: decode the address into zero-extended register contents.
    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            REG_CNT: bus_rdata[CNT_W-1:0]    = count;
            REG_CTL: bus_rdata[CTL_BITS-1:0] = ctl;
            REG_FLG: bus_rdata[FLAG_POS]     = flag;
            default: bus_rdata               = '0;
        endcase
    end

    p_flag_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_FLG) |-> ((bus_rdata & ~FLAG_MASK) == '0));

    p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == {CNT_W{1'b1}}) |=> (flag && count == '0));
endmodule

// File: tb/free_run_timer_bench.sv
`timescale 1ns/1ps
module free_run_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [1:0] A_CNT = 2'd0;
    localparam logic [1:0] A_CTL = 2'd1;
    localparam logic [1:0] A_FLG = 2'd2;
    localparam logic [1:0] A_NON = 2'd3;

    always #2.5 clk = ~clk;

    free_run_timer u_free_run_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Row: {sel, wr, addr[1:0], wdata[15:0], expected pre-edge rdata[15:0]}
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000},  // R1 count
        {1'b1, 1'b0, 2'd1, 16'h0000, 16'h0000},  // R1 control
        {1'b1, 1'b0, 2'd2, 16'h0000, 16'h0000},  // R1 status
        {1'b1, 1'b0, 2'd3, 16'h0000, 16'h0000},  // R11 unmapped
        {1'b1, 1'b1, 2'd0, 16'h1234, 16'h0000},  // R8 write count
        {1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000},  // R8 count unchanged
        {1'b1, 1'b1, 2'd1, 16'hFFFE, 16'h0000},  // R11 control write
        {1'b1, 1'b0, 2'd1, 16'h0000, 16'h0006},  // R11 low bits only
        {1'b1, 1'b1, 2'd1, 16'h0000, 16'h0006},  // R11 control clear
        {1'b1, 1'b0, 2'd1, 16'h0000, 16'h0000},  // R11 readback
        {1'b1, 1'b1, 2'd2, 16'hFFFF, 16'h0000},  // R6 clear idle flag
        {1'b1, 1'b0, 2'd2, 16'h0000, 16'h0000}   // R5 status zero
    };

    function automatic string row_tag(int i);
        case (i)
            0, 1, 2:        return "R1";
            4, 5:           return "R8";
            3, 6, 7, 8, 9:  return "R11";
            10:             return "R6";
            default:        return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // One bus cycle starting at a falling edge; returns at the next one.
    task automatic bus(logic s, logic w, logic [1:0] a, logic [15:0] d);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 16'h0000;
    endtask

    // Look at a register without making an access.
    task automatic peek(logic [1:0] a, output logic [15:0] v);
        bus_sel = 1'b0; bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    // Idle until the count shows a given value (no access, so no fast clear).
    task automatic wait_count(logic [15:0] val);
        logic [15:0] v;
        forever begin
            peek(A_CNT, v);
            if (v == val) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (199_800) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {15'd0, irq}, 16'h0000);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            bus_sel = VEC[i][35]; bus_wr = VEC[i][34];
            bus_addr = VEC[i][33:32]; bus_wdata = VEC[i][31:16];
            #0.5;
            check(row_tag(i), bus_rdata, VEC[i][15:0]);
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
        end

        // R2: counting after run is enabled
        bus(1'b1, 1'b1, A_CTL, 16'h0001);
        peek(A_CNT, v); check("R2 start", v, 16'h0000);
        repeat (10) @(negedge clk);
        peek(A_CNT, v); check("R2 ten steps", v, 16'd10);

        // R3: stop holds the count
        bus(1'b1, 1'b1, A_CTL, 16'h0000);
        peek(A_CNT, v); check("R3 stop", v, 16'd11);
        repeat (5) @(negedge clk);
        peek(A_CNT, v); check("R3 hold", v, 16'd11);

        // Wrap 1 with a write-one clear on the same edge (R10, R4)
        bus(1'b1, 1'b1, A_CTL, 16'h0001);
        wait_count(16'hFFFF);
        bus(1'b1, 1'b1, A_FLG, 16'h0080);
        peek(A_CNT, v); check("R2 wrap to zero", v, 16'h0000);
        peek(A_FLG, v); check("R10 set wins", v, 16'h0080);
        check("R9 masked irq", {15'd0, irq}, 16'h0000);

        // R7: fast clear off, counter accesses leave the flag
        bus(1'b1, 1'b0, A_CNT, 16'h0000);
        peek(A_FLG, v); check("R7 read no fast", v, 16'h0080);
        peek(A_CNT, c0);
        bus(1'b1, 1'b1, A_CNT, 16'h5555);
        peek(A_FLG, v); check("R7 write no fast", v, 16'h0080);
        peek(A_CNT, v); check("R8 write ignored", v, c0 + 16'd1);

        // R6: write with bit 7 clear has no effect
        bus(1'b1, 1'b1, A_FLG, 16'h007F);
        peek(A_FLG, v); check("R6 zero write", v, 16'h0080);

        // R9: interrupt enable shows the pending flag and holds it
        bus(1'b1, 1'b1, A_CTL, 16'h0005);
        check("R9 irq up", {15'd0, irq}, 16'h0001);
        repeat (3) @(negedge clk);
        check("R9 irq held", {15'd0, irq}, 16'h0001);

        // R6: write-one clear drops flag and irq
        bus(1'b1, 1'b1, A_FLG, 16'h0080);
        peek(A_FLG, v); check("R6 clear", v, 16'h0000);
        check("R9 irq down", {15'd0, irq}, 16'h0000);

        // Wrap 2: fast-clear by reading the counter
        wait_count(16'hFFFF);
        @(negedge clk);
        peek(A_FLG, v); check("R4 second wrap", v, 16'h0080);
        check("R9 irq on wrap", {15'd0, irq}, 16'h0001);
        bus(1'b1, 1'b1, A_CTL, 16'h0007);
        bus(1'b1, 1'b0, A_CNT, 16'h0000);
        peek(A_FLG, v); check("R7 fast read clear", v, 16'h0000);
        check("R9 irq after fast", {15'd0, irq}, 16'h0000);

        // Wrap 3: fast-clear by writing the counter
        wait_count(16'hFFFF);
        @(negedge clk);
        peek(A_FLG, v); check("R4 third wrap", v, 16'h0080);
        peek(A_CNT, c0);
        bus(1'b1, 1'b1, A_CNT, 16'hABCD);
        peek(A_FLG, v); check("R7 fast write clear", v, 16'h0000);
        peek(A_CNT, v); check("R8 count kept", v, c0 + 16'd1);

        // R1: mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        peek(A_CNT, v); check("R1 count reset", v, 16'h0000);
        peek(A_CTL, v); check("R1 control reset", v, 16'h0000);
        peek(A_FLG, v); check("R1 status reset", v, 16'h0000);
        check("R1 irq reset", {15'd0, irq}, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule